// File: doc/BRIEF.md
# Bit-Block Transfer Address Sequencer

This block is the control half of a rectangular block-transfer engine. After a start command it walks a destination rectangle in memory one word at a time. When the selected source/pattern combination needs one, it also walks a source rectangle of the same shape. For every destination word it issues, in a fixed order, the source fetches, the destination read and the destination write. It places each request on a request/acknowledge memory port and holds it there until the memory accepts it.

The sequencer keeps 23-bit word addresses, a words-left-in-line counter, a lines-left counter and a 4-bit pattern row index. The row index moves up or down at each line end, following the sign of the destination per-line increment. For each write it picks one of three masks by the word's position in the line. It decides, from the combining codes and that mask, whether the destination must be read first. Two per-transfer flags shape the source traffic: one primes the source buffer with an extra fetch at the start of each line, and the other drops the last fetch of each line. The data combining itself lies outside this block; the block only tells the memory side which kind of access each request is.

Top module: `blit_seq`

## Requirements
- R1: After reset `busy`, `mem_req`, the counters and the row index are all zero.
- R2: A `start` pulse while idle latches every configuration input and raises `busy` on the next clock edge. A `start` pulse while busy has no effect on the running transfer.
- R3: A request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_is_src` unchanged until `mem_ack` is sampled high on a rising edge.
- R4: `words_i` gives the destination words per line and `lines_i` the number of lines, and the value 0 stands for 65536. `words_left_o` counts down by one per write and reloads `words_i` after the last write of a line. `lines_left_o` counts down by one per line and reads 0 once the transfer ends.
- R5: Each increment is a signed 16-bit byte offset. Its bit 0 is ignored, and the word step equals the increment shifted right arithmetically by one. After a source fetch or destination write, the matching address steps by its per-line (Y) increment when that word is the last of its line, and by its per-word (X) increment otherwise. The address outputs always show the next address to be used.
- R6: A write to the first word of a line uses `mask_first_i`, a write to the last word uses `mask_last_i`, and every other write uses `mask_mid_i`. A one-word line uses `mask_first_i`. `mem_wmask` carries the chosen mask during writes and reads 0 otherwise.
- R7: With `prime_i` set and source data in use, one extra source fetch precedes the normal fetch of the first word of each line.
- R8: With `skip_last_i` set and source data in use, the last word of each line gets no source fetch. With `skip_last_i` set, the last write of each line is always preceded by a destination read.
- R9: Result bit for source bit s and destination bit d is `lop_i[{s,d}]`. The destination is read before a write only when the code depends on d, or the active mask is not 16'hFFFF, or R8 forces it. So codes 0, 3, 12 and 15 with an all-ones mask write without reading.
- R10: Source fetches (`mem_is_src`=1) happen only when `hmode_i` is 2 or 3. Code 0 means all ones, 1 means pattern only, 2 means source, and 3 means source AND pattern.
- R11: At every line end `line_o` increments modulo 16 when bit 15 of the destination Y increment is clear, and decrements modulo 16 when it is set.
- R12: Per word, the access order is the extra source fetch, then the source fetch, then the destination read, then the write. `busy` drops in the cycle after the acknowledge of the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (honoured only while idle) |
| src_base_i | input | 23 | Source start word address |
| dst_base_i | input | 23 | Destination start word address |
| src_xstep_i | input | 16 | Source per-word byte increment |
| src_ystep_i | input | 16 | Source per-line byte increment |
| dst_xstep_i | input | 16 | Destination per-word byte increment |
| dst_ystep_i | input | 16 | Destination per-line byte increment |
| words_i | input | 16 | Words per line (0 = 65536) |
| lines_i | input | 16 | Lines per transfer (0 = 65536) |
| mask_first_i | input | 16 | Mask for the first write of a line |
| mask_mid_i | input | 16 | Mask for interior writes |
| mask_last_i | input | 16 | Mask for the last write of a line |
| hmode_i | input | 2 | Source/pattern combining code |
| lop_i | input | 4 | Source/destination logic code |
| prime_i | input | 1 | Extra source fetch at each line start |
| skip_last_i | input | 1 | No source fetch for the last word of each line |
| line_i | input | 4 | Initial pattern row index |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a destination write |
| mem_is_src | output | 1 | Request is a source fetch |
| mem_addr | output | 23 | Word address of the request |
| mem_wmask | output | 16 | Bit mask of the current write |
| busy | output | 1 | Transfer in progress |
| src_addr_o | output | 23 | Next source address |
| dst_addr_o | output | 23 | Next destination address |
| words_left_o | output | 16 | Words left in the current line |
| lines_left_o | output | 16 | Lines left |
| line_o | output | 4 | Current pattern row index |

## Verification
The situation hardest to reach from the ports is a count loaded as zero, which stands for 65536. A full run of that size would outlast any reasonable test. The bench therefore starts a transfer with a zero word count and lets a few writes complete. It then reads the counter and address outputs and ends the transfer with a reset. The priming and skipped-fetch flags matter only at line ends in combination with source use, so dedicated transfers pair them with one-word lines and with source-free codes. A second start pulse during a busy transfer, carrying different settings, shows whether the latched configuration is kept.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int BLT_AW = 23;   // word address width
    localparam int BLT_DW = 16;   // data / mask width
    localparam int BLT_IW = 16;   // increment width (byte offsets)
    localparam int BLT_CW = 16;   // counter width
    localparam int BLT_LW = 4;    // pattern row index width

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_XSRC,
        PH_SRC,
        PH_DRD,
        PH_DWR
    } phase_e;

    // which optional accesses the current word needs
    typedef struct packed {
        logic xsrc;
        logic src;
        logic drd;
    } need_t;

    // position of the current word in the field
    typedef struct packed {
        logic first;
        logic last;
        logic last_line;
    } pos_t;

    // result bit is op[{s,d}]; it depends on d when either pair differs
    function automatic logic op_reads_dst(input logic [3:0] op);
        return (op[0] ^ op[1]) | (op[2] ^ op[3]);
    endfunction

    // codes 2 and 3 bring source data into the combination
    function automatic logic hop_reads_src(input logic [1:0] hop);
        return hop[1];
    endfunction

    // first required access after the given phase within one word
    function automatic phase_e next_phase(input phase_e from, input need_t n);
        phase_e r;
        r = PH_DWR;
        if (from == PH_START && n.xsrc)
            r = PH_XSRC;
        else if ((from == PH_START || from == PH_XSRC) && n.src)
            r = PH_SRC;
        else if ((from == PH_START || from == PH_XSRC || from == PH_SRC) && n.drd)
            r = PH_DRD;
        return r;
    endfunction

endpackage

// File: rtl/blit_addr_unit.sv
module blit_addr_unit
    import blit_pkg::*;
#(
    parameter int AW = BLT_AW,
    parameter int IW = BLT_IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          use_y,
    input  logic [IW-1:0] xinc,
    input  logic [IW-1:0] yinc,
    output logic [AW-1:0] addr
);
    localparam int EXT = AW - IW + 1;

    logic [IW-1:0] inc_sel;
    logic [AW-1:0] word_step;
    logic [AW-1:0] addr_q;

    assign inc_sel   = use_y ? yinc : xinc;
    // byte offset to word offset: drop bit 0, keep sign
    assign word_step = {{EXT{inc_sel[IW-1]}}, inc_sel[IW-1:1]};

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load)
            addr_q <= load_val;
        else if (step)
            addr_q <= addr_q + word_step;
    end

    assign addr = addr_q;

endmodule

// File: rtl/blit_line_ctr.sv
module blit_line_ctr
    import blit_pkg::*;
#(
    parameter int CW = BLT_CW,
    parameter int LW = BLT_LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] words_init,
    input  logic [CW-1:0] lines_init,
    input  logic [LW-1:0] line_init,
    input  logic          row_down,
    input  logic          word_done,
    output pos_t          pos,
    output logic [CW-1:0] words_left,
    output logic [CW-1:0] lines_left,
    output logic [LW-1:0] row
);
    logic [CW-1:0] words_init_q;
    logic [CW-1:0] words_q;
    logic [CW-1:0] lines_q;
    logic [LW-1:0] row_q;
    logic          down_q;
    logic          end_of_line;

    assign end_of_line = (words_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            words_init_q <= '0;
            words_q      <= '0;
            lines_q      <= '0;
            row_q        <= '0;
            down_q       <= 1'b0;
        end else if (load) begin
            words_init_q <= words_init;
            words_q      <= words_init;
            lines_q      <= lines_init;
            row_q        <= line_init;
            down_q       <= row_down;
        end else if (word_done) begin
            if (end_of_line) begin
                words_q <= words_init_q;
                lines_q <= lines_q - CW'(1);
                row_q   <= down_q ? row_q - LW'(1) : row_q + LW'(1);
            end else begin
                words_q <= words_q - CW'(1);
            end
        end
    end

    assign pos.first     = (words_q == words_init_q);
    assign pos.last      = end_of_line;
    assign pos.last_line = (lines_q == CW'(1));
    assign words_left    = words_q;
    assign lines_left    = lines_q;
    assign row           = row_q;

    // a line end always moves the row index by one step
    p_row_moves_r11: assert property (@(posedge clk) disable iff (rst)
        (word_done && !load && end_of_line) |=> (row_q != $past(row_q)));

endmodule

// File: rtl/blit_mask_sel.sv
module blit_mask_sel
    import blit_pkg::*;
#(
    parameter int DW = BLT_DW
) (
    input  pos_t          pos,
    input  logic [DW-1:0] mask_first,
    input  logic [DW-1:0] mask_mid,
    input  logic [DW-1:0] mask_last,
    input  logic [1:0]    hop,
    input  logic [3:0]    op,
    input  logic          prime,
    input  logic          skip_last,
    output logic [DW-1:0] mask,
    output need_t         need
);
    logic src_used;
    logic forced_rmw;

    always_comb begin
        if (pos.first)
            mask = mask_first;
        else if (pos.last)
            mask = mask_last;
        else
            mask = mask_mid;
    end

    assign src_used   = hop_reads_src(hop);
    assign forced_rmw = skip_last && pos.last;

    assign need.xsrc = src_used && prime && pos.first;
    assign need.src  = src_used && !forced_rmw;
    assign need.drd  = op_reads_dst(op) || (mask != {DW{1'b1}}) || forced_rmw;

endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
#(
    parameter int AW = BLT_AW,
    parameter int DW = BLT_DW,
    parameter int IW = BLT_IW,
    parameter int CW = BLT_CW,
    parameter int LW = BLT_LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] src_base_i,
    input  logic [AW-1:0] dst_base_i,
    input  logic [IW-1:0] src_xstep_i,
    input  logic [IW-1:0] src_ystep_i,
    input  logic [IW-1:0] dst_xstep_i,
    input  logic [IW-1:0] dst_ystep_i,
    input  logic [CW-1:0] words_i,
    input  logic [CW-1:0] lines_i,
    input  logic [DW-1:0] mask_first_i,
    input  logic [DW-1:0] mask_mid_i,
    input  logic [DW-1:0] mask_last_i,
    input  logic [1:0]    hmode_i,
    input  logic [3:0]    lop_i,
    input  logic          prime_i,
    input  logic          skip_last_i,
    input  logic [LW-1:0] line_i,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_is_src,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wmask,
    output logic          busy,
    output logic [AW-1:0] src_addr_o,
    output logic [AW-1:0] dst_addr_o,
    output logic [CW-1:0] words_left_o,
    output logic [CW-1:0] lines_left_o,
    output logic [LW-1:0] line_o
);
    phase_e        phase_q, phase_d;
    logic          launch;
    logic [IW-1:0] sxi_q, syi_q, dxi_q, dyi_q;
    logic [DW-1:0] m1_q, m2_q, m3_q;
    logic [1:0]    hop_q;
    logic [3:0]    op_q;
    logic          prime_q, skip_q;
    logic          saw_drd_q;
    pos_t          pos;
    need_t         need;
    logic [DW-1:0] cur_mask;
    logic          src_phase;
    logic          src_step, dst_step;

    assign launch    = (phase_q == PH_IDLE) && start;
    assign src_phase = (phase_q == PH_XSRC) || (phase_q == PH_SRC);
    assign src_step  = src_phase && mem_ack;
    assign dst_step  = (phase_q == PH_DWR) && mem_ack;

    // configuration held for the whole transfer
    always_ff @(posedge clk) begin
        if (rst) begin
            sxi_q <= '0; syi_q <= '0; dxi_q <= '0; dyi_q <= '0;
            m1_q <= '0; m2_q <= '0; m3_q <= '0;
            hop_q <= '0; op_q <= '0; prime_q <= 1'b0; skip_q <= 1'b0;
        end else if (launch) begin
            sxi_q   <= src_xstep_i;
            syi_q   <= src_ystep_i;
            dxi_q   <= dst_xstep_i;
            dyi_q   <= dst_ystep_i;
            m1_q    <= mask_first_i;
            m2_q    <= mask_mid_i;
            m3_q    <= mask_last_i;
            hop_q   <= hmode_i;
            op_q    <= lop_i;
            prime_q <= prime_i;
            skip_q  <= skip_last_i;
        end
    end

    blit_addr_unit #(.AW(AW), .IW(IW)) u_src_addr (
        .clk(clk), .rst(rst), .load(launch), .load_val(src_base_i),
        .step(src_step), .use_y(pos.last), .xinc(sxi_q), .yinc(syi_q),
        .addr(src_addr_o)
    );

    blit_addr_unit #(.AW(AW), .IW(IW)) u_dst_addr (
        .clk(clk), .rst(rst), .load(launch), .load_val(dst_base_i),
        .step(dst_step), .use_y(pos.last), .xinc(dxi_q), .yinc(dyi_q),
        .addr(dst_addr_o)
    );

    blit_line_ctr #(.CW(CW), .LW(LW)) u_ctr (
        .clk(clk), .rst(rst), .load(launch),
        .words_init(words_i), .lines_init(lines_i), .line_init(line_i),
        .row_down(dst_ystep_i[IW-1]), .word_done(dst_step),
        .pos(pos), .words_left(words_left_o), .lines_left(lines_left_o),
        .row(line_o)
    );

    blit_mask_sel #(.DW(DW)) u_mask (
        .pos(pos), .mask_first(m1_q), .mask_mid(m2_q), .mask_last(m3_q),
        .hop(hop_q), .op(op_q), .prime(prime_q), .skip_last(skip_q),
        .mask(cur_mask), .need(need)
    );

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (start) phase_d = PH_START;
            PH_START: phase_d = next_phase(PH_START, need);
            PH_XSRC, PH_SRC, PH_DRD:
                if (mem_ack) phase_d = next_phase(phase_q, need);
            PH_DWR:
                if (mem_ack) phase_d = (pos.last && pos.last_line) ? PH_IDLE : PH_START;
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            saw_drd_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if ((phase_q == PH_DRD) && mem_ack)
                saw_drd_q <= 1'b1;
            else if (dst_step || launch)
                saw_drd_q <= 1'b0;
        end
    end

    assign mem_req    = src_phase || (phase_q == PH_DRD) || (phase_q == PH_DWR);
    assign mem_we     = (phase_q == PH_DWR);
    assign mem_is_src = src_phase;
    assign mem_addr   = src_phase ? src_addr_o : dst_addr_o;
    assign mem_wmask  = mem_we ? cur_mask : '0;
    assign busy       = (phase_q != PH_IDLE);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_is_src)));

    p_rmw_last_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DWR && pos.last && skip_q) |-> saw_drd_q);

    p_src_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_is_src) |-> (hop_q == 2'd2 || hop_q == 2'd3));

    p_busy_end_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(mem_ack && mem_we));

endmodule

// File: tb/blit_seq_tb.sv
module blit_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [22:0] src_base_i = '0, dst_base_i = '0;
    logic [15:0] src_xstep_i = '0, src_ystep_i = '0, dst_xstep_i = '0, dst_ystep_i = '0;
    logic [15:0] words_i = '0, lines_i = '0;
    logic [15:0] mask_first_i = '0, mask_mid_i = '0, mask_last_i = '0;
    logic [1:0]  hmode_i = '0;
    logic [3:0]  lop_i = '0;
    logic        prime_i = 1'b0, skip_last_i = 1'b0;
    logic [3:0]  line_i = '0;
    logic        mem_ack = 1'b0;
    logic        mem_req, mem_we, mem_is_src, busy;
    logic [22:0] mem_addr, src_addr_o, dst_addr_o;
    logic [15:0] mem_wmask, words_left_o, lines_left_o;
    logic [3:0]  line_o;

    always #2.5 clk = ~clk;  // 200 MHz

    blit_seq u_dut (
        .clk(clk), .rst(rst), .start(start),
        .src_base_i(src_base_i), .dst_base_i(dst_base_i),
        .src_xstep_i(src_xstep_i), .src_ystep_i(src_ystep_i),
        .dst_xstep_i(dst_xstep_i), .dst_ystep_i(dst_ystep_i),
        .words_i(words_i), .lines_i(lines_i),
        .mask_first_i(mask_first_i), .mask_mid_i(mask_mid_i), .mask_last_i(mask_last_i),
        .hmode_i(hmode_i), .lop_i(lop_i), .prime_i(prime_i), .skip_last_i(skip_last_i),
        .line_i(line_i), .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_is_src(mem_is_src),
        .mem_addr(mem_addr), .mem_wmask(mem_wmask), .busy(busy),
        .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
        .words_left_o(words_left_o), .lines_left_o(lines_left_o), .line_o(line_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lat = 0;
    int wcnt = 0;
    int ack_cyc = 0;
    bit done = 0;

    // access log: kind 0 = source fetch, 1 = destination read, 2 = write
    int ob_k[256], ob_a[256], ob_m[256];
    int n_ob = 0;
    int ex_k[256], ex_a[256], ex_m[256];
    int n_ex = 0;
    int ex_src_end, ex_dst_end, ex_line;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                if (n_ob < 256) begin
                    ob_k[n_ob] = mem_we ? 2 : (mem_is_src ? 0 : 1);
                    ob_a[n_ob] = int'(mem_addr);
                    ob_m[n_ob] = int'(mem_wmask);
                    n_ob++;
                end
                mem_ack = 1'b1;
                wcnt = 0;
                ack_cyc = cyc;
            end else begin
                wcnt++;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int wstep(input int a, input logic [15:0] inc);
        int d;
        d = int'($signed(inc) >>> 1);
        return (a + d) & 32'h7F_FFFF;
    endfunction

    function automatic void push(input int k, input int a, input int m);
        ex_k[n_ex] = k; ex_a[n_ex] = a; ex_m[n_ex] = m;
        n_ex++;
    endfunction

    // expected access stream from the requirements (R5..R12)
    task automatic build_model();
        int nx, ny, sa, da, ln, msk;
        bit first, last, srcu, dep;
        nx = (words_i == 0) ? 65536 : int'(words_i);
        ny = (lines_i == 0) ? 65536 : int'(lines_i);
        sa = int'(src_base_i); da = int'(dst_base_i); ln = int'(line_i);
        n_ex = 0;
        srcu = hmode_i[1];
        dep  = (lop_i[0] != lop_i[1]) || (lop_i[2] != lop_i[3]);
        for (int l = 0; l < ny; l++) begin
            for (int w = 0; w < nx; w++) begin
                first = (w == 0);
                last  = (w == nx - 1);
                if (srcu && prime_i && first) begin
                    push(0, sa, 0);
                    sa = wstep(sa, last ? src_ystep_i : src_xstep_i);
                end
                if (srcu && !(last && skip_last_i)) begin
                    push(0, sa, 0);
                    sa = wstep(sa, last ? src_ystep_i : src_xstep_i);
                end
                msk = first ? int'(mask_first_i) : (last ? int'(mask_last_i) : int'(mask_mid_i));
                if (dep || msk != 'hFFFF || (last && skip_last_i))
                    push(1, da, 0);
                push(2, da, msk);
                da = wstep(da, last ? dst_ystep_i : dst_xstep_i);
            end
            ln = dst_ystep_i[15] ? ((ln + 15) % 16) : ((ln + 1) % 16);
        end
        ex_src_end = sa; ex_dst_end = da; ex_line = ln;
    endtask

    // run one transfer and compare against the model
    task automatic do_xfer(input string req, input bit mid_start);
        int fall, guard, wi;
        build_model();
        wi = int'(words_i);
        n_ob = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        if (mid_start) begin
            repeat (3) @(negedge clk);
            words_i = 16'd7; dst_base_i = 23'h7000; hmode_i = 2'd0; lop_i = 4'd0;
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        fall = cyc;
        chk(n_ob == n_ex, req, "access count", n_ob, n_ex);
        for (int i = 0; i < n_ex && i < n_ob; i++) begin
            chk(ob_k[i] == ex_k[i], req, $sformatf("kind #%0d", i), ob_k[i], ex_k[i]);
            chk(ob_a[i] == ex_a[i], req, $sformatf("addr #%0d", i), ob_a[i], ex_a[i]);
            if (ex_k[i] == 2)
                chk(ob_m[i] == ex_m[i], "R6", $sformatf("mask #%0d", i), ob_m[i], ex_m[i]);
        end
        chk(fall == ack_cyc + 1, "R12", "busy drop cycle", fall, ack_cyc + 1);
        chk(int'(src_addr_o) == ex_src_end, "R5", "final src addr", int'(src_addr_o), ex_src_end);
        chk(int'(dst_addr_o) == ex_dst_end, "R5", "final dst addr", int'(dst_addr_o), ex_dst_end);
        chk(int'(line_o) == ex_line, "R11", "final row", int'(line_o), ex_line);
        chk(lines_left_o == 16'd0, "R4", "lines left at end", int'(lines_left_o), 0);
        chk(int'(words_left_o) == wi, "R4", "words reloaded", int'(words_left_o), wi);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(mem_req == 1'b0, "R1", "req in reset", mem_req, 0);
        chk(words_left_o == 16'd0 && lines_left_o == 16'd0, "R1", "counters in reset",
            int'(words_left_o), 0);
        chk(line_o == 4'd0, "R1", "row in reset", int'(line_o), 0);
    endtask

    task automatic t_fill();  // R9 no reads, R11 row up
        lat = 0;
        hmode_i = 2'd0; lop_i = 4'h0; prime_i = 0; skip_last_i = 0;
        mask_first_i = 16'hFFFF; mask_mid_i = 16'hFFFF; mask_last_i = 16'hFFFF;
        words_i = 16'd3; lines_i = 16'd2; line_i = 4'd5;
        dst_base_i = 23'h100; dst_xstep_i = 16'd2; dst_ystep_i = 16'h00A0;
        do_xfer("R9", 0);
    endtask

    task automatic t_copy();  // R5 signed odd steps, R6 masks, R10 source, R2 ignore
        lat = 2;
        hmode_i = 2'd2; lop_i = 4'h3; prime_i = 0; skip_last_i = 0;
        mask_first_i = 16'h0FFF; mask_mid_i = 16'hFFFF; mask_last_i = 16'hFFF0;
        words_i = 16'd4; lines_i = 16'd3; line_i = 4'd1;
        src_base_i = 23'h2000; src_xstep_i = 16'd4; src_ystep_i = 16'hFFF1;
        dst_base_i = 23'h4000; dst_xstep_i = 16'hFFFE; dst_ystep_i = 16'hFF81;
        do_xfer("R10", 1);
    endtask

    task automatic t_prime_skip();  // R7 extra fetch, R8 skipped fetch + RMW
        lat = 1;
        hmode_i = 2'd3; lop_i = 4'h3; prime_i = 1; skip_last_i = 1;
        mask_first_i = 16'hFFFF; mask_mid_i = 16'hFFFF; mask_last_i = 16'hFFFF;
        words_i = 16'd3; lines_i = 16'd2; line_i = 4'd0;
        src_base_i = 23'h10; src_xstep_i = 16'd2; src_ystep_i = 16'd10;
        dst_base_i = 23'h300; dst_xstep_i = 16'd2; dst_ystep_i = 16'd40;
        do_xfer("R8", 0);
    endtask

    task automatic t_single_nosrc();  // R6 one-word line, R10 pattern only, R11 wrap
        lat = 0;
        hmode_i = 2'd1; lop_i = 4'h5; prime_i = 1; skip_last_i = 0;
        mask_first_i = 16'h00F0; mask_mid_i = 16'hFFFF; mask_last_i = 16'hFFFF;
        words_i = 16'd1; lines_i = 16'd3; line_i = 4'd15;
        dst_base_i = 23'h500; dst_xstep_i = 16'd2; dst_ystep_i = 16'd160;
        do_xfer("R6", 0);
    endtask

    task automatic t_single_src();  // R7 prime on one-word lines, R9 code 12 no read
        lat = 1;
        hmode_i = 2'd2; lop_i = 4'hC; prime_i = 1; skip_last_i = 0;
        mask_first_i = 16'hFFFF; mask_mid_i = 16'h0000; mask_last_i = 16'h0000;
        words_i = 16'd1; lines_i = 16'd2; line_i = 4'd0;
        src_base_i = 23'h7FFFF0; src_xstep_i = 16'd2; src_ystep_i = 16'd8;
        dst_base_i = 23'h20; dst_xstep_i = 16'd2; dst_ystep_i = 16'hFFFC;
        do_xfer("R7", 0);
    endtask

    task automatic t_big();  // R4 zero word count means 65536
        int guard;
        lat = 0;
        hmode_i = 2'd0; lop_i = 4'hF; prime_i = 0; skip_last_i = 0;
        mask_first_i = 16'hFFFF; mask_mid_i = 16'hFFFF; mask_last_i = 16'hFFFF;
        words_i = 16'd0; lines_i = 16'd1; line_i = 4'd3;
        dst_base_i = 23'h1000; dst_xstep_i = 16'd2; dst_ystep_i = 16'd2;
        n_ob = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        guard = 0;
        while (n_ob < 3 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk(words_left_o == 16'hFFFD, "R4", "words left after 3", int'(words_left_o), 'hFFFD);
        chk(dst_addr_o == 23'h1003, "R4", "dst addr after 3", int'(dst_addr_o), 'h1003);
        chk(busy == 1'b1, "R4", "still busy", busy, 1);
        chk(line_o == 4'd3, "R11", "row holds mid-line", int'(line_o), 3);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0, "R1", "reset ends transfer", busy, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_fill();
        t_copy();
        t_prime_skip();
        t_single_nosrc();
        t_single_src();
        t_big();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule